// File: doc/BRIEF.md
# AES Column Mixing Unit

This unit applies the AES column mixing transform, forward or inverse, to one 32-bit state column per operation. The caller presents a column, picks the direction and pulses a start strobe. The unit returns the mixed column together with a done flag.

Every step works on the whole column at once. A single word-wide doubler multiplies each byte by {02} in GF(2^8), and each byte lane is reduced on its own. A forward operation combines the doubled column, the tripled column and the plain column in one step. An inverse operation runs three doubling passes, which give the {02}, {04} and {08} multiples of the column. It then forms the {09}, {0B}, {0D} and {0E} multiples from those registers with XOR alone, so it needs no general field multiplier. The unit serves as the mixing stage of a round datapath in which other logic handles substitution, row shifting and key handling.

Top module: `mixcol_unit`

## Requirements
- R1: While rstN is low, and on the first cycle after it is released, colOut is 0 and done is 0.
- R2: Byte lane i of a column occupies bits [8i+7:8i], so lane 0 is bits [7:0]. The {02} product of a byte is the byte shifted left one bit, XORed with 0x1B when the bit shifted out was 1. No bit moves from one lane into another.
- R3: A forward operation gives out_i = {02}·a_i ^ {03}·a_(i+1) ^ a_(i+2) ^ a_(i+3), with lane indices taken mod 4 and {03}·x = {02}·x ^ x.
- R4: A forward start (start=1, inverse=0) sampled at a clock edge while the unit is idle puts the result on colOut and raises done right after that same edge. Forward starts on consecutive edges each produce a result.
- R5: An inverse operation gives out_i = {0E}·a_i ^ {0B}·a_(i+1) ^ {0D}·a_(i+2) ^ {09}·a_(i+3), with lane indices taken mod 4.
- R6: For an inverse start (start=1, inverse=1) sampled at edge E0, done stays 0 after E0, E1 and E2. The result and done appear after E3.
- R7: done is high for exactly one cycle per completed operation. colOut holds its value between completions.
- R8: For the three cycles after an inverse start is accepted, start, inverse and colIn are ignored. The result comes from the column captured at acceptance, and no extra completion follows.
- R9: An inverse operation applied to the result of a forward operation returns the original column.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins an operation when the unit is idle |
| inverse | input | 1 | 1 selects the inverse transform, 0 the forward transform |
| colIn | input | 32 | Input column, lane i at bits [8i+7:8i] |
| colOut | output | 32 | Mixed column from the last completed operation |
| done | output | 1 | One-cycle pulse when colOut is updated |

## Verification
The bench builds the unit with its default parameters: four byte lanes of eight bits each, with reduction constant 0x1B. This is the only setting in which the circulant coefficients mean anything. At that setting the bench checks known column vectors and random columns against a bit-serial field multiplier model. It also checks lane patterns with the top bit set, where a carry leaking across a lane would show, and forward-then-inverse round trips. Starts issued while an inverse is running bring the ignore path and the fixed four-edge latency within reach.

// File: rtl/mixcol_pkg.sv
package mixcol_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_QUAD = 2'd1,
    ST_OCT  = 2'd2,
    ST_COMB = 2'd3
  } mixState_t;

  typedef struct packed {
    logic loadIn;
    logic stage4;
    logic stage8;
    logic writeFwd;
    logic writeInv;
  } mixStrobes_t;

endpackage

// File: rtl/mixcol_dbl.sv
module mixcol_dbl #(
  parameter int LANES = 4,
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] POLY = 8'h1B,
  localparam int COL_W = LANES * BYTE_W
) (
  input  logic [COL_W-1:0] wordIn,
  output logic [COL_W-1:0] wordOut
);

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    localparam int LO = ln * BYTE_W;
    logic [BYTE_W-1:0] laneIn;
    assign laneIn = wordIn[LO +: BYTE_W];
    assign wordOut[LO +: BYTE_W] = {laneIn[BYTE_W-2:0], 1'b0}
                                   ^ (laneIn[BYTE_W-1] ? POLY : '0);
  end

endmodule

// File: rtl/mixcol_ctrl.sv
module mixcol_ctrl
  import mixcol_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        inverse,
  output mixStrobes_t strobes,
  output logic        busy
);

  mixState_t state, stateNext;

  always_comb begin
    strobes   = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (start && !inverse) begin
          strobes.loadIn   = 1'b1;
          strobes.writeFwd = 1'b1;
        end else if (start && inverse) begin
          strobes.loadIn = 1'b1;
          stateNext      = ST_QUAD;
        end
      end
      ST_QUAD: begin
        strobes.stage4 = 1'b1;
        stateNext      = ST_OCT;
      end
      ST_OCT: begin
        strobes.stage8 = 1'b1;
        stateNext      = ST_COMB;
      end
      ST_COMB: begin
        strobes.writeInv = 1'b1;
        stateNext        = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state != ST_IDLE);

  // R8: while an inverse runs, no new load or forward write may be issued
  a_r8_no_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobes.loadIn && !strobes.writeFwd);

  // R6: the combine step always comes two steps after the quad step
  a_r6_inv_sequence: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stage4 |=> strobes.stage8 ##1 strobes.writeInv);

endmodule

// File: rtl/mixcol_dp.sv
module mixcol_dp
  import mixcol_pkg::*;
#(
  parameter int LANES = 4,
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] POLY = 8'h1B,
  localparam int COL_W = LANES * BYTE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  mixStrobes_t      strobes,
  input  logic [COL_W-1:0] colIn,
  output logic [COL_W-1:0] colOut,
  output logic             done
);

  logic [COL_W-1:0] xReg, d2Reg, d4Reg, d8Reg, resReg;
  logic [COL_W-1:0] dblIn, dblOut;
  logic [COL_W-1:0] fwdMix, invMix;
  logic [COL_W-1:0] m9, mB, mD, mE;
  logic             doneReg;

  function automatic logic [COL_W-1:0] rotLanes(input logic [COL_W-1:0] w,
                                                input int k);
    logic [COL_W-1:0] r;
    r = '0;
    for (int i = 0; i < LANES; i++)
      r[i*BYTE_W +: BYTE_W] = w[((i + k) % LANES)*BYTE_W +: BYTE_W];
    return r;
  endfunction

  always_comb begin
    if (strobes.stage4)      dblIn = d2Reg;
    else if (strobes.stage8) dblIn = d4Reg;
    else                     dblIn = colIn;
  end

  mixcol_dbl #(.LANES(LANES), .BYTE_W(BYTE_W), .POLY(POLY)) u_dbl (
    .wordIn (dblIn),
    .wordOut(dblOut)
  );

  always_comb begin
    fwdMix = dblOut ^ rotLanes(dblOut ^ colIn, 1)
           ^ rotLanes(colIn, 2) ^ rotLanes(colIn, 3);
    m9 = d8Reg ^ xReg;
    mB = d8Reg ^ d2Reg ^ xReg;
    mD = d8Reg ^ d4Reg ^ xReg;
    mE = d8Reg ^ d4Reg ^ d2Reg;
    invMix = mE ^ rotLanes(mB, 1) ^ rotLanes(mD, 2) ^ rotLanes(m9, 3);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xReg    <= '0;
      d2Reg   <= '0;
      d4Reg   <= '0;
      d8Reg   <= '0;
      resReg  <= '0;
      doneReg <= 1'b0;
    end else begin
      if (strobes.loadIn) begin
        xReg  <= colIn;
        d2Reg <= dblOut;
      end
      if (strobes.stage4) d4Reg <= dblOut;
      if (strobes.stage8) d8Reg <= dblOut;
      if (strobes.writeFwd)      resReg <= fwdMix;
      else if (strobes.writeInv) resReg <= invMix;
      doneReg <= strobes.writeFwd | strobes.writeInv;
    end
  end

  assign colOut = resReg;
  assign done   = doneReg;

  // R8: the captured column does not move while the inverse steps run
  a_r8_capture_held: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stage4 || strobes.stage8) |=> $stable(xReg));

endmodule

// File: rtl/mixcol_unit.sv
module mixcol_unit #(
  parameter int LANES = 4,
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] POLY = 8'h1B,
  localparam int COL_W = LANES * BYTE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             inverse,
  input  logic [COL_W-1:0] colIn,
  output logic [COL_W-1:0] colOut,
  output logic             done
);

  mixcol_pkg::mixStrobes_t strobes;
  logic busy;

  mixcol_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .inverse(inverse),
    .strobes(strobes),
    .busy   (busy)
  );

  mixcol_dp #(.LANES(LANES), .BYTE_W(BYTE_W), .POLY(POLY)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .colIn  (colIn),
    .colOut (colOut),
    .done   (done)
  );

  // R4: an idle forward start completes right after the sampling edge
  a_r4_fwd_one_step: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && !inverse) |=> done);

  // R6: an idle inverse start shows no completion on the next edge
  a_r6_inv_not_early: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && inverse) |=> (busy && !done));

  // R7: the result only changes together with a done pulse
  a_r7_result_held: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(colOut));

  // R7: an inverse completion is a single-cycle pulse
  a_r7_inv_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (done && !$past(start)) |=> (!done || $past(start && !busy)));

endmodule

// File: tb/mixcol_unit_test.sv
module mixcol_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        inverse = 1'b0;
  logic [31:0] colIn = '0;
  logic [31:0] colOut;
  logic        done;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  mixcol_unit uut (
    .clk(clk), .rstN(rstN), .start(start), .inverse(inverse),
    .colIn(colIn), .colOut(colOut), .done(done)
  );

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    logic [7:0] aa = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ aa;
      aa = aa[7] ? ((aa << 1) ^ 8'h1B) : (aa << 1);
    end
    return p;
  endfunction

  function automatic logic [31:0] refMix(input logic [31:0] c, input bit inv);
    logic [7:0] k0 = inv ? 8'h0E : 8'h02;
    logic [7:0] k1 = inv ? 8'h0B : 8'h03;
    logic [7:0] k2 = inv ? 8'h0D : 8'h01;
    logic [7:0] k3 = inv ? 8'h09 : 8'h01;
    logic [31:0] r = '0;
    for (int i = 0; i < 4; i++)
      r[i*8 +: 8] = gmul(k0, c[i*8 +: 8]) ^ gmul(k1, c[((i+1)%4)*8 +: 8])
                  ^ gmul(k2, c[((i+2)%4)*8 +: 8]) ^ gmul(k3, c[((i+3)%4)*8 +: 8]);
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Runs one operation from idle and checks timing, value and the pulse end.
  task automatic doOp(input logic [31:0] c, input bit inv, input string req);
    logic [31:0] exp = refMix(c, inv);
    @(negedge clk);
    colIn = c; inverse = inv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!inv) begin
      check({req, " R4 done"}, {31'd0, done}, 32'd1);
      check({req, " R4 value"}, colOut, exp);
    end else begin
      check({req, " R6 done after E0"}, {31'd0, done}, 32'd0);
      for (int s = 0; s < 2; s++) begin
        @(negedge clk);
        check({req, " R6 done early"}, {31'd0, done}, 32'd0);
      end
      @(negedge clk);
      check({req, " R6 done"}, {31'd0, done}, 32'd1);
      check({req, " R6 value"}, colOut, exp);
    end
    @(negedge clk);
    check({req, " R7 pulse end"}, {31'd0, done}, 32'd0);
    check({req, " R7 hold"}, colOut, exp);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] c, f, keep;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 reset out", colOut, 32'h0);
    check("R1 reset done", {31'd0, done}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 post-reset out", colOut, 32'h0);
    check("R1 post-reset done", {31'd0, done}, 32'd0);

    // Known column vector, lane 0 = 0xdb
    doOp(32'h455313db, 1'b0, "R3 known");
    check("R3 known exact", colOut, 32'hbca14d8e);
    doOp(32'hbca14d8e, 1'b1, "R5 known");
    check("R5 known exact", colOut, 32'h455313db);

    // Lane isolation with top bits set
    doOp(32'h80808080, 1'b0, "R2 all-top");
    check("R2 all-top exact", colOut, 32'h80808080);
    doOp(32'h00000080, 1'b0, "R2 single lane");
    doOp(32'h80000000, 1'b1, "R2 inverse top lane");
    doOp(32'hffffffff, 1'b1, "R2 all-ones inverse");

    // Back-to-back forward starts
    @(negedge clk);
    start = 1'b1; inverse = 1'b0;
    for (int k = 0; k < 3; k++) begin
      c = $urandom;
      colIn = c;
      @(negedge clk);
      check("R4 back-to-back done", {31'd0, done}, 32'd1);
      check("R4 back-to-back value", colOut, refMix(c, 1'b0));
    end
    start = 1'b0;
    @(negedge clk);

    // Starts during an inverse are ignored
    c = 32'h0123abcd;
    colIn = c; inverse = 1'b1; start = 1'b1;
    @(negedge clk);
    colIn = 32'hdeadbeef; inverse = 1'b0; start = 1'b1;
    @(negedge clk);
    check("R8 no completion E1", {31'd0, done}, 32'd0);
    colIn = 32'h55aa55aa; inverse = 1'b1;
    @(negedge clk);
    check("R8 no completion E2", {31'd0, done}, 32'd0);
    start = 1'b0;
    @(negedge clk);
    check("R8 done", {31'd0, done}, 32'd1);
    check("R8 captured value", colOut, refMix(c, 1'b1));
    keep = colOut;
    @(negedge clk);
    check("R8 no extra completion", {31'd0, done}, 32'd0);
    check("R8 value kept", colOut, keep);

    // Round trips
    for (int k = 0; k < 20; k++) begin
      c = $urandom;
      doOp(c, 1'b0, "R9 fwd");
      f = colOut;
      doOp(f, 1'b1, "R9 inv");
      check("R9 round trip", colOut, c);
    end

    // Random mix
    for (int k = 0; k < 150; k++) begin
      c = $urandom;
      doOp(c, ($urandom % 2) == 1, "R3 R5 random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule